// File: doc/BRIEF.md
# Hamming-Coded Parallel Channel Corrector

Four identical linear processing channels (filters, transforms) run side by side. Three extra copies of the same channel are fed sums of selected channel inputs. Because the channels are linear, the output of each extra copy should equal the same sum of the main outputs. This block receives the four main outputs and the three redundant outputs as signed fixed-point samples under one shared valid strobe. It forms the three expected sums and compares each one against its redundant output within a tolerance. The pass/fail pattern is treated as a Hamming syndrome.

When the syndrome points at a main channel, the block rebuilds that channel's sample from one redundant output minus two healthy main outputs, and saturates the result to the sample width. When only one comparison fails, the fault lies in a redundant channel. In that case the main samples pass through untouched and a separate flag is raised. Results appear two clock cycles after the inputs, with a registered syndrome, a fault index and flags.

Top module: `par_chan_corrector`

## Requirements
- R1: Check k (k = 1, 2, 3) fails when the absolute difference between redundant output zk and its sum exceeds `tol`. The sums are y1+y2+y3 for check 1, y1+y2+y4 for check 2 and y1+y3+y4 for check 3. `out_syn` bit 0 holds check 1, bit 1 holds check 2 and bit 2 holds check 3. Channels y1..y4 are ports `y0`..`y3`, and z1..z3 are ports `z0`..`z2`.
- R2: Syndrome 3'b111 marks channel 1 as faulty (`out_idx` = 0). Its output is replaced by z1 − y2 − y3.
- R3: Syndrome 3'b011 marks channel 2 as faulty (`out_idx` = 1). Its output is replaced by z1 − y1 − y3.
- R4: Syndrome 3'b101 marks channel 3 as faulty (`out_idx` = 2). Its output is replaced by z1 − y1 − y2.
- R5: Syndrome 3'b110 marks channel 4 as faulty (`out_idx` = 3). Its output is replaced by z2 − y1 − y2.
- R6: When exactly one check fails, `out_red` = 1, `out_err` = 1, `out_corr` = 0 and `out_idx` = 0, and all four main samples pass through unchanged.
- R7: When no check fails, all flags are 0, `out_syn` = 0, `out_idx` = 0 and the samples pass through unchanged.
- R8: A rebuilt sample saturates to the signed DW-bit range: above 2^(DW−1)−1 it becomes that maximum, and below −2^(DW−1) it becomes that minimum.
- R9: `out_valid` rises exactly two clock edges after an `in_valid` cycle. Back-to-back inputs produce back-to-back results.
- R10: A synchronous active-high reset clears `out_valid`, `out_err`, `out_corr` and `out_red`.
- R11: A difference equal to `tol` passes, and with `tol` = 0 any nonzero difference fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Shared strobe for all seven input samples |
| tol | input | DW | Unsigned comparison tolerance |
| y0 | input | DW | Main channel 1 output, signed |
| y1 | input | DW | Main channel 2 output, signed |
| y2 | input | DW | Main channel 3 output, signed |
| y3 | input | DW | Main channel 4 output, signed |
| z0 | input | DW | Redundant output 1, signed |
| z1 | input | DW | Redundant output 2, signed |
| z2 | input | DW | Redundant output 3, signed |
| out_valid | output | 1 | Result strobe |
| out_y0 | output | DW | Corrected channel 1 |
| out_y1 | output | DW | Corrected channel 2 |
| out_y2 | output | DW | Corrected channel 3 |
| out_y3 | output | DW | Corrected channel 4 |
| out_syn | output | 3 | Syndrome, one bit per check |
| out_idx | output | 2 | Faulty main channel index |
| out_err | output | 1 | At least one check failed |
| out_corr | output | 1 | A main channel was rebuilt |
| out_red | output | 1 | A redundant channel is faulty |

## Verification
The assertions assume that `in_valid` is held low while reset is asserted, and that every input sample is a defined value in the cycle it is strobed. Under those assumptions the pipeline registers never carry stale data into a valid result. The stimulus drives inputs only between clock edges and builds each vector from a clean, consistent set in which at most one sample is disturbed. The exception is the saturation vectors, which are deliberately inconsistent. The flag relations asserted (single-bit syndrome excludes correction, correction implies at least two failing checks) therefore hold for every vector applied.

// File: rtl/pcc_check.sv
module pcc_check #(
  parameter int DW   = 16,
  parameter int EXCL = 3
) (
  input  logic signed [DW-1:0] y [4],
  input  logic signed [DW-1:0] z,
  input  logic        [DW-1:0] tol,
  output logic                 fail
);
  localparam int SW  = DW + 2;
  localparam int DFW = DW + 3;

  logic signed [SW-1:0]  sum;
  logic signed [DFW-1:0] diff;
  logic        [DFW-1:0] mag;

  // Three-operand sum of the channels this check covers, widened by two bits
  always_comb begin
    sum = '0;
    for (int c = 0; c < 4; c++) begin
      if (c != EXCL) sum = sum + SW'(y[c]);
    end
    diff = DFW'(z) - DFW'(sum);
    mag  = diff[DFW-1] ? DFW'(-diff) : DFW'(diff);
    fail = mag > DFW'(tol);
  end
endmodule

// File: rtl/pcc_decode.sv
module pcc_decode (
  input  logic [2:0] syn,
  output logic       err,
  output logic       corr,
  output logic       red,
  output logic [1:0] idx
);
  always_comb begin
    err  = |syn;
    corr = 1'b0;
    red  = 1'b0;
    idx  = 2'd0;
    case (syn)
      3'b111: begin corr = 1'b1; idx = 2'd0; end
      3'b011: begin corr = 1'b1; idx = 2'd1; end
      3'b101: begin corr = 1'b1; idx = 2'd2; end
      3'b110: begin corr = 1'b1; idx = 2'd3; end
      3'b001, 3'b010, 3'b100: red = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pcc_rebuild.sv
module pcc_rebuild #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] y  [4],
  input  logic signed [DW-1:0] z  [3],
  input  logic [1:0]           idx,
  input  logic                 corr,
  output logic signed [DW-1:0] yo [4]
);
  localparam int SW = DW + 2;
  localparam logic signed [SW-1:0] MAXV = {3'b000, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {3'b111, {(DW-1){1'b0}}};

  for (genvar c = 0; c < 4; c++) begin : g_ch
    // Redundant output and the two healthy partners used to rebuild channel c
    localparam int ZI = (c == 3) ? 1 : 0;
    localparam int A  = (c == 0) ? 1 : 0;
    localparam int B  = (c < 2)  ? 2 : 1;

    logic signed [SW-1:0] rec;
    logic signed [DW-1:0] rec_sat;

    always_comb begin
      rec = SW'(z[ZI]) - SW'(y[A]) - SW'(y[B]);
      if (rec > MAXV)      rec_sat = MAXV[DW-1:0];
      else if (rec < MINV) rec_sat = MINV[DW-1:0];
      else                 rec_sat = rec[DW-1:0];
      yo[c] = (corr && idx == 2'(c)) ? rec_sat : y[c];
    end
  end
endmodule

// File: rtl/par_chan_corrector.sv
module par_chan_corrector #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic        [DW-1:0] tol,
  input  logic signed [DW-1:0] y0,
  input  logic signed [DW-1:0] y1,
  input  logic signed [DW-1:0] y2,
  input  logic signed [DW-1:0] y3,
  input  logic signed [DW-1:0] z0,
  input  logic signed [DW-1:0] z1,
  input  logic signed [DW-1:0] z2,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_y0,
  output logic signed [DW-1:0] out_y1,
  output logic signed [DW-1:0] out_y2,
  output logic signed [DW-1:0] out_y3,
  output logic [2:0]           out_syn,
  output logic [1:0]           out_idx,
  output logic                 out_err,
  output logic                 out_corr,
  output logic                 out_red
);
  localparam int NCH = 4;
  localparam int NRD = 3;

  logic signed [DW-1:0] yv [NCH];
  logic signed [DW-1:0] zv [NRD];
  logic [NRD-1:0]       fail;

  assign yv[0] = y0;
  assign yv[1] = y1;
  assign yv[2] = y2;
  assign yv[3] = y3;
  assign zv[0] = z0;
  assign zv[1] = z1;
  assign zv[2] = z2;

  // Check k covers every main channel except channel NCH-1-k
  for (genvar k = 0; k < NRD; k++) begin : g_chk
    pcc_check #(.DW(DW), .EXCL(NCH - 1 - k)) u_chk (
      .y   (yv),
      .z   (zv[k]),
      .tol (tol),
      .fail(fail[k])
    );
  end

  // Stage 1: syndrome and sample copies
  logic                 s1_valid;
  logic [2:0]           s1_syn;
  logic signed [DW-1:0] s1_y [NCH];
  logic signed [DW-1:0] s1_z [NRD];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_syn   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_syn <= fail;
        for (int c = 0; c < NCH; c++) s1_y[c] <= yv[c];
        for (int k = 0; k < NRD; k++) s1_z[k] <= zv[k];
      end
    end
  end

  // Stage 2: decode, rebuild, output registers
  logic                 d_err, d_corr, d_red;
  logic [1:0]           d_idx;
  logic signed [DW-1:0] fixed [NCH];

  pcc_decode u_dec (
    .syn (s1_syn),
    .err (d_err),
    .corr(d_corr),
    .red (d_red),
    .idx (d_idx)
  );

  pcc_rebuild #(.DW(DW)) u_fix (
    .y   (s1_y),
    .z   (s1_z),
    .idx (d_idx),
    .corr(d_corr),
    .yo  (fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_corr  <= 1'b0;
      out_red   <= 1'b0;
      out_syn   <= '0;
      out_idx   <= '0;
      out_y0    <= '0;
      out_y1    <= '0;
      out_y2    <= '0;
      out_y3    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_err  <= d_err;
        out_corr <= d_corr;
        out_red  <= d_red;
        out_syn  <= s1_syn;
        out_idx  <= d_idx;
        out_y0   <= fixed[0];
        out_y1   <= fixed[1];
        out_y2   <= fixed[2];
        out_y3   <= fixed[3];
      end
    end
  end

  // R9: each result is preceded by a stage-1 entry, which is preceded by an input
  a_r9_stage1_from_input: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> $past(in_valid));
  a_r9_out_from_stage1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s1_valid));
  // R6: a lone failing check never triggers a rebuild
  a_r6_red_no_corr: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_red) |-> (!out_corr && $countones(out_syn) == 1));
  // R2..R5: a rebuild always follows at least two failing checks
  a_r2_corr_multi: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_corr) |-> ($countones(out_syn) >= 2));
  // R7: a clean result carries no syndrome, index or rebuild
  a_r7_clean_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |-> (out_syn == 3'b000 && out_idx == 2'd0 && !out_corr && !out_red));
  // R6/R7: without a rebuild the samples leave exactly as stage 1 held them
  a_r6_passthrough: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_corr) |->
      (out_y0 == $past(s1_y[0]) && out_y1 == $past(s1_y[1]) &&
       out_y2 == $past(s1_y[2]) && out_y3 == $past(s1_y[3])));
endmodule

// File: tb/par_chan_corrector_test.sv
module par_chan_corrector_test;
  localparam int DW = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int MAXI = (1 << (DW - 1)) - 1;
  localparam int MINI = -(1 << (DW - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] tol = '0;
  logic signed [DW-1:0] y0 = '0, y1 = '0, y2 = '0, y3 = '0, z0 = '0, z1 = '0, z2 = '0;
  logic out_valid, out_err, out_corr, out_red;
  logic signed [DW-1:0] out_y0, out_y1, out_y2, out_y3;
  logic [2:0] out_syn;
  logic [1:0] out_idx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  par_chan_corrector #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .tol(tol),
    .y0(y0), .y1(y1), .y2(y2), .y3(y3), .z0(z0), .z1(z1), .z2(z2),
    .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2), .out_y3(out_y3),
    .out_syn(out_syn), .out_idx(out_idx), .out_err(out_err), .out_corr(out_corr), .out_red(out_red)
  );

  typedef struct {
    int    ey [4];
    int    syn, idx, err, corr, red;
    int    stamp;
    string req;
  } exp_t;

  exp_t expq [$];
  int   nvec = 0;
  int   nbad = 0;
  int   cyc  = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sat(input int v);
    if (v > MAXI) return MAXI;
    if (v < MINI) return MINI;
    return v;
  endfunction

  // Reference model written from the requirements
  task automatic send(input int a0, a1, a2, a3, b0, b1, b2, t, input string req);
    exp_t e;
    int ya [4];
    int za [3];
    int s  [3];
    int f  [3];
    ya = '{a0, a1, a2, a3};
    za = '{b0, b1, b2};
    s[0] = ya[0] + ya[1] + ya[2];   // R1 check 1
    s[1] = ya[0] + ya[1] + ya[3];   // R1 check 2
    s[2] = ya[0] + ya[2] + ya[3];   // R1 check 3
    for (int k = 0; k < 3; k++) begin
      int d;
      d = za[k] - s[k];
      if (d < 0) d = -d;
      f[k] = (d > t) ? 1 : 0;
    end
    e.syn = f[0] | (f[1] << 1) | (f[2] << 2);
    e.ey = ya;
    e.err = (e.syn != 0) ? 1 : 0;
    e.corr = 0; e.red = 0; e.idx = 0;
    case (e.syn)
      7: begin e.corr = 1; e.idx = 0; e.ey[0] = sat(za[0] - ya[1] - ya[2]); end
      3: begin e.corr = 1; e.idx = 1; e.ey[1] = sat(za[0] - ya[0] - ya[2]); end
      5: begin e.corr = 1; e.idx = 2; e.ey[2] = sat(za[0] - ya[0] - ya[1]); end
      6: begin e.corr = 1; e.idx = 3; e.ey[3] = sat(za[1] - ya[0] - ya[1]); end
      1, 2, 4: e.red = 1;
      default: ;
    endcase
    e.req = req;
    @(negedge clk);
    y0 = DW'(a0); y1 = DW'(a1); y2 = DW'(a2); y3 = DW'(a3);
    z0 = DW'(b0); z1 = DW'(b1); z2 = DW'(b2);
    tol = DW'(t);
    in_valid = 1'b1;
    e.stamp = cyc;
    expq.push_back(e);
  endtask

  // Clean vector with optional disturbance on one main (fch) and one redundant (zch) sample
  task automatic send_fault(input int a0, a1, a2, a3, fch, fd, zch, zd, t, input string req);
    int ya [4];
    int za [3];
    ya = '{a0, a1, a2, a3};
    za[0] = ya[0] + ya[1] + ya[2];
    za[1] = ya[0] + ya[1] + ya[3];
    za[2] = ya[0] + ya[2] + ya[3];
    if (fch >= 0) ya[fch] = ya[fch] + fd;
    if (zch >= 0) za[zch] = za[zch] + zd;
    send(ya[0], ya[1], ya[2], ya[3], za[0], za[1], za[2], t, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expectation per result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        nvec++; nbad++;
        $display("FAIL R9 unexpected result: got out_valid=1 exp out_valid=0");
      end else begin
        exp_t e;
        int got [4];
        bit bad;
        e = expq.pop_front();
        got = '{int'(out_y0), int'(out_y1), int'(out_y2), int'(out_y3)};
        bad = 1'b0;
        nvec++;
        for (int c = 0; c < 4; c++)
          if (got[c] != e.ey[c]) begin
            bad = 1'b1;
            $display("FAIL %s ch%0d: got %0d exp %0d", e.req, c, got[c], e.ey[c]);
          end
        if (int'(out_syn) != e.syn || int'(out_idx) != e.idx || int'(out_err) != e.err ||
            int'(out_corr) != e.corr || int'(out_red) != e.red) begin
          bad = 1'b1;
          $display("FAIL %s flags: got syn=%0d idx=%0d err=%0d corr=%0d red=%0d exp syn=%0d idx=%0d err=%0d corr=%0d red=%0d",
                   e.req, out_syn, out_idx, out_err, out_corr, out_red, e.syn, e.idx, e.err, e.corr, e.red);
        end
        if (cyc - e.stamp != 2) begin
          bad = 1'b1;
          $display("FAIL R9 latency (%s): got %0d exp 2", e.req, cyc - e.stamp);
        end
        if (bad) nbad++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    nvec++;
    if (out_valid !== 1'b0 || out_err !== 1'b0 || out_corr !== 1'b0 || out_red !== 1'b0) begin
      nbad++;
      $display("FAIL R10 reset: got v=%b e=%b c=%b r=%b exp 0 0 0 0", out_valid, out_err, out_corr, out_red);
    end
    rst = 1'b0;
    idle(2);

    send_fault(100, -200, 300, -400, -1, 0, -1, 0, 0, "R7");
    send_fault(100, -200, 300, -400, -1, 0, 0, 1, 0, "R11");       // tol 0, diff 1 fails
    send_fault(100, -200, 300, -400, -1, 0, 0, 3, 3, "R11");       // diff equals tol
    send_fault(100, -200, 300, -400, -1, 0, 0, 4, 3, "R6");        // syn 001
    send_fault(100, -200, 300, -400, -1, 0, 1, -9, 0, "R6");       // syn 010
    send_fault(100, -200, 300, -400, -1, 0, 2, -50, 0, "R6");      // syn 100
    send_fault(100, -200, 300, -400, 0, 100, -1, 0, 0, "R2");
    send_fault(100, -200, 300, -400, 1, -77, -1, 0, 0, "R3");
    send_fault(100, -200, 300, -400, 2, 5, -1, 0, 0, "R4");
    send_fault(100, -200, 300, -400, 3, -1, -1, 0, 0, "R5");
    idle(3);
    send_fault(100, -200, 300, -400, 0, 7, -1, 0, 10, "R1");       // within tolerance
    send_fault(100, -200, 300, -400, 3, -8, -1, 0, 8, "R1");
    send_fault(20000, -15000, 12000, -30000, 1, 9999, -1, 0, 0, "R3");
    send_fault(20000, -15000, 12000, -30000, 3, 2000, -1, 0, 5, "R5");
    idle(1);
    send(0, -10000, -10000, 0, 30000, 5000, 5000, 0, "R8");        // clip high
    send(0, 10000, 10000, 0, -30000, -5000, -5000, 0, "R8");       // clip low
    idle(2);
    for (int i = 0; i < 8; i++)
      send_fault(i * 37 - 100, 55 - i, i * i, -3 * i, i % 4, i + 1, -1, 0, 0, "R9");
    idle(6);

    if (expq.size() != 0) begin
      nvec++; nbad++;
      $display("FAIL R9 pending results: got %0d exp 0", expq.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule